// File: doc/BRIEF.md
# Aperture Remapping Table Unit

This unit translates bus addresses that fall inside one fixed window into physical addresses, one 4 KiB page at a time. Each page of the window has one table entry. An entry holds a physical frame number and a valid flag. A lookup port accepts an address and returns the translated address one clock later. The translated address is the entry's frame joined with the page offset of the incoming address. The lookup returns a fault instead when translation is switched off, when the address lies outside the window, or when the entry for that page is not valid.

Software reaches the table only indirectly, through a three-word register file on a simple memory-mapped bus. It first writes a window address into a select register. It then reads or writes a data register, which acts on the entry for the selected page. A global enable bit in a configuration register gates all translation. Because a read of that register returns its current value, software can use the read to wait until earlier writes are complete.

The window base and the number of pages are parameters. Reset clears the enable bit and invalidates every entry.

Top module: `aperture_remap_unit`

## Requirements
- R1: After reset, the enable bit reads 0, every entry reads as 0 (not valid), and the lookup outputs `lk_vld`, `lk_fault` and `lk_paddr` are 0.
- R2: The configuration register sits at byte offset 0x0. A write sets the enable bit from data bit 0. A read returns the enable bit in bit 0, with bits 31:1 reading 0.
- R3: The select register sits at offset 0x4 and holds a full 32-bit window address. A read returns the last value written. The selected page is (select - base) >> 12.
- R4: The data register sits at offset 0x8. A write stores data bit 31 as the valid flag and bits 30:12 as the frame into the selected entry. A read returns {valid, frame, 12'h000}. Writing 0 invalidates the entry.
- R5: When the select value lies outside the window, a data write changes no entry and a data read returns 0.
- R6: An address is inside the window if and only if base <= address <= base + pages*4096 - 1. This holds for both the select register and the lookup port.
- R7: A lookup raised with `lk_req` in one cycle produces `lk_vld` = 1 in the next cycle. When there is no fault, `lk_paddr` = {1'b0, frame, lk_addr[11:0]}.
- R8: A lookup reports `lk_fault` = 1 with `lk_paddr` = 0 in any of three cases: the enable bit is 0, the address is outside the window, or the entry is not valid.
- R9: When a data write and a lookup hit the same entry in the same cycle, the lookup returns the entry's value from before the write.
- R10: A register read returns data on `reg_rdata` one cycle after `reg_rd_en`, and `reg_rdata` holds that value until the next read. Offsets other than 0x0, 0x4 and 0x8 read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after the read strobe |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 32 | Address to translate |
| lk_vld | output | 1 | Lookup result is present |
| lk_fault | output | 1 | Lookup failed |
| lk_paddr | output | 32 | Translated physical address, 0 on a fault |

## Verification
The assertions check the following on every cycle:
- the one-cycle lookup latency;
- the zero address returned with every fault;
- forced faults when translation is disabled or the address is outside the window;
- the page offset passing through on a successful translation;
- the enable bit following configuration writes;
- zero reads through an out-of-window select;
- each table write landing in the addressed entry.

Only the bench scenarios can show the rest. These cover the exact window edges at base-1, base and the last byte, a select just past the window that would alias onto page 0, the old value returned when a lookup collides with a write, and agreement with a reference table under random programming.

// File: rtl/art_pkg.sv
// Package: shared entry type and register offsets for the remapping unit.
// Assumes 32-bit addresses and 4 KiB pages.
package art_pkg;
    localparam int ADDR_W     = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int FRAME_W    = 19;   // entry bits 30:12

    localparam logic [3:0] OFS_CFG  = 4'h0;
    localparam logic [3:0] OFS_SEL  = 4'h4;
    localparam logic [3:0] OFS_DATA = 4'h8;

    typedef struct packed {
        logic               valid;
        logic [FRAME_W-1:0] frame;
    } art_entry_t;
endpackage

// File: rtl/art_window.sv
// Module: art_window
// Decides whether an address is inside the window and gives its page index.
// Assumes BASE is page aligned and PAGE_COUNT is at least 1.
module art_window #(
    parameter logic [31:0] BASE       = 32'h4000_0000,
    parameter int          PAGE_COUNT = 64,
    parameter int          IDX_W      = 6
) (
    input  logic [31:0]      addr,
    output logic             in_win,
    output logic [IDX_W-1:0] idx
);
    localparam logic [32:0] SPAN = 33'(PAGE_COUNT) << art_pkg::PAGE_SHIFT;

    logic [32:0] diff;

    // Offset from base; bit 32 set means below base.
    always_comb begin
        diff   = {1'b0, addr} - {1'b0, BASE};
        in_win = !diff[32] && ({1'b0, diff[31:0]} < SPAN);
        idx    = diff[art_pkg::PAGE_SHIFT +: IDX_W];
    end
endmodule

// File: rtl/art_table.sv
// Module: art_table
// Entry storage: one write port and two combinational read ports.
// Assumes the caller writes only indices inside the window. Entries beyond
// PAGE_COUNT (power-of-two padding) stay zero.
module art_table #(
    parameter int IDX_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [IDX_W-1:0]    widx,
    input  art_pkg::art_entry_t wentry,
    input  logic [IDX_W-1:0]    ridx_a,
    output art_pkg::art_entry_t rentry_a,
    input  logic [IDX_W-1:0]    ridx_b,
    output art_pkg::art_entry_t rentry_b
);
    localparam int DEPTH = 1 << IDX_W;

    art_pkg::art_entry_t mem [DEPTH];

    // Store entries; reset invalidates all of them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[widx] <= wentry;
        end
    end

    // Read ports return the stored value (old value during a write).
    always_comb begin
        rentry_a = mem[ridx_a];
        rentry_b = mem[ridx_b];
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(widx)] == $past(wentry)); // R4
endmodule

// File: rtl/art_regfile.sv
// Module: art_regfile
// Register file holding the enable bit and the select register, and giving
// indirect access to the table. Assumes at most one access per cycle.
module art_regfile #(
    parameter logic [31:0] BASE       = 32'h4000_0000,
    parameter int          PAGE_COUNT = 64,
    parameter int          IDX_W      = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr_en,
    input  logic                reg_rd_en,
    input  logic [3:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic                xlat_en,
    output logic                tab_we,
    output logic [IDX_W-1:0]    tab_idx,
    output art_pkg::art_entry_t tab_wentry,
    input  art_pkg::art_entry_t tab_rentry
);
    import art_pkg::*;

    logic [31:0] sel_q;
    logic        sel_in_win;

    art_window #(.BASE(BASE), .PAGE_COUNT(PAGE_COUNT), .IDX_W(IDX_W)) u_sel_win (
        .addr   (sel_q),
        .in_win (sel_in_win),
        .idx    (tab_idx)
    );

    // Table write request for data-register writes inside the window.
    always_comb begin
        tab_we           = reg_wr_en && (reg_addr == OFS_DATA) && sel_in_win;
        tab_wentry.valid = reg_wdata[31];
        tab_wentry.frame = reg_wdata[30:PAGE_SHIFT];
    end

    // Configuration and select register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xlat_en <= 1'b0;
            sel_q   <= '0;
        end else if (reg_wr_en) begin
            if (reg_addr == OFS_CFG) xlat_en <= reg_wdata[0];
            if (reg_addr == OFS_SEL) sel_q   <= reg_wdata;
        end
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd_en) begin
            case (reg_addr)
                OFS_CFG:  reg_rdata <= {31'b0, xlat_en};
                OFS_SEL:  reg_rdata <= sel_q;
                OFS_DATA: reg_rdata <= sel_in_win ?
                                       {tab_rentry.valid, tab_rentry.frame, 12'h000} : 32'h0;
                default:  reg_rdata <= 32'h0;
            endcase
        end
    end

    AST_CFG_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == OFS_CFG) |=> xlat_en == $past(reg_wdata[0])); // R2
    AST_OOW_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && reg_addr == OFS_DATA && !sel_in_win) |=> reg_rdata == 32'h0); // R5
endmodule

// File: rtl/art_lookup.sv
// Module: art_lookup
// Lookup pipeline: window check, entry fetch and fault decision, all
// registered in one stage. Assumes the table read port is combinational.
module art_lookup #(
    parameter logic [31:0] BASE       = 32'h4000_0000,
    parameter int          PAGE_COUNT = 64,
    parameter int          IDX_W      = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                xlat_en,
    input  logic                lk_req,
    input  logic [31:0]         lk_addr,
    output logic [IDX_W-1:0]    ent_idx,
    input  art_pkg::art_entry_t ent,
    output logic                lk_vld,
    output logic                lk_fault,
    output logic [31:0]         lk_paddr
);
    logic in_win;
    logic miss;

    art_window #(.BASE(BASE), .PAGE_COUNT(PAGE_COUNT), .IDX_W(IDX_W)) u_lk_win (
        .addr   (lk_addr),
        .in_win (in_win),
        .idx    (ent_idx)
    );

    // Any of the three fault causes.
    always_comb miss = !xlat_en || !in_win || !ent.valid;

    // Register the translation result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_vld   <= 1'b0;
            lk_fault <= 1'b0;
            lk_paddr <= '0;
        end else begin
            lk_vld <= lk_req;
            if (lk_req) begin
                lk_fault <= miss;
                lk_paddr <= miss ? 32'h0 :
                            {1'b0, ent.frame, lk_addr[art_pkg::PAGE_SHIFT-1:0]};
            end
        end
    end

    AST_LK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> lk_vld); // R7
    AST_LK_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_vld && !lk_fault) |-> lk_paddr[11:0] == $past(lk_addr[11:0])); // R7
    AST_LK_DISABLED_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && !xlat_en) |=> lk_fault); // R8
    AST_LK_OOW_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && !in_win) |=> lk_fault); // R6
    AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_vld && lk_fault) |-> lk_paddr == 32'h0); // R8
endmodule

// File: rtl/aperture_remap_unit.sv
// Module: aperture_remap_unit
// Top level: a register file for programming the table, the entry table,
// and a one-stage lookup path. Assumes BASE is 4 KiB aligned and
// BASE + PAGE_COUNT*4096 does not exceed the 32-bit space.
module aperture_remap_unit #(
    parameter logic [31:0] BASE       = 32'h4000_0000,
    parameter int          PAGE_COUNT = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic        reg_rd_en,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        lk_req,
    input  logic [31:0] lk_addr,
    output logic        lk_vld,
    output logic        lk_fault,
    output logic [31:0] lk_paddr
);
    localparam int IDX_W = (PAGE_COUNT > 1) ? $clog2(PAGE_COUNT) : 1;

    logic                xlat_en;
    logic                tab_we;
    logic [IDX_W-1:0]    reg_idx;
    logic [IDX_W-1:0]    lk_idx;
    art_pkg::art_entry_t tab_wentry;
    art_pkg::art_entry_t reg_entry;
    art_pkg::art_entry_t lk_entry;

    art_regfile #(.BASE(BASE), .PAGE_COUNT(PAGE_COUNT), .IDX_W(IDX_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr_en  (reg_wr_en),
        .reg_rd_en  (reg_rd_en),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .xlat_en    (xlat_en),
        .tab_we     (tab_we),
        .tab_idx    (reg_idx),
        .tab_wentry (tab_wentry),
        .tab_rentry (reg_entry)
    );

    art_table #(.IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (tab_we),
        .widx     (reg_idx),
        .wentry   (tab_wentry),
        .ridx_a   (reg_idx),
        .rentry_a (reg_entry),
        .ridx_b   (lk_idx),
        .rentry_b (lk_entry)
    );

    art_lookup #(.BASE(BASE), .PAGE_COUNT(PAGE_COUNT), .IDX_W(IDX_W)) u_lookup (
        .clk      (clk),
        .rst_n    (rst_n),
        .xlat_en  (xlat_en),
        .lk_req   (lk_req),
        .lk_addr  (lk_addr),
        .ent_idx  (lk_idx),
        .ent      (lk_entry),
        .lk_vld   (lk_vld),
        .lk_fault (lk_fault),
        .lk_paddr (lk_paddr)
    );
endmodule

// File: tb/aperture_remap_unit_tb_top.sv
// Bench: directed window-edge cases plus seeded random programming and
// lookups, compared against a reference table kept in the bench.
module aperture_remap_unit_tb_top;
    localparam logic [31:0] BASE  = 32'h4000_0000;
    localparam int          PAGES = 64;
    localparam longint      SPAN  = longint'(PAGES) * 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_req = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        lk_vld, lk_fault;
    logic [31:0] lk_paddr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] m_tab [PAGES];
    logic        m_en;
    logic [31:0] m_sel;

    always #2.5 clk = ~clk;

    aperture_remap_unit #(.BASE(BASE), .PAGE_COUNT(PAGES)) dut_i (
        .clk, .rst_n, .reg_wr_en, .reg_rd_en, .reg_addr, .reg_wdata, .reg_rdata,
        .lk_req, .lk_addr, .lk_vld, .lk_fault, .lk_paddr
    );

    function automatic bit in_win(logic [31:0] a);
        return (longint'(a) >= longint'(BASE)) && (longint'(a) <= longint'(BASE) + SPAN - 1);
    endfunction

    function automatic int page_of(logic [31:0] a);
        return int'((longint'(a) - longint'(BASE)) / 4096);
    endfunction

    function automatic logic [32:0] exp_lookup(logic [31:0] a);
        // returns {fault, paddr}
        if (!m_en || !in_win(a) || !m_tab[page_of(a)][31]) return {1'b1, 32'h0};
        return {1'b0, 1'b0, m_tab[page_of(a)][30:12], a[11:0]};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        if (a == 4'h0) m_en = d[0];
        if (a == 4'h4) m_sel = d;
        if (a == 4'h8 && in_win(m_sel)) m_tab[page_of(m_sel)] = {d[31:12], 12'h000};
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd_en = 1'b0;
        d = reg_rdata;
    endtask

    task automatic look(string req, logic [31:0] a);
        logic [32:0] e;
        e = exp_lookup(a);
        @(negedge clk);
        lk_req = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_req = 1'b0;
        chk({req, " vld"}, {31'b0, lk_vld}, 32'h1);
        chk({req, " fault"}, {31'b0, lk_fault}, {31'b0, e[32]});
        chk({req, " paddr"}, lk_paddr, e[31:0]);
    endtask

    task automatic rd_entry(string req, logic [31:0] sel);
        logic [31:0] v;
        wr(4'h4, sel);
        rd(4'h8, v);
        chk(req, v, in_win(sel) ? m_tab[page_of(sel)] : 32'h0);
    endtask

    function automatic logic [31:0] rnd_addr();
        return BASE - 32'h2000 + ($urandom % (32'(SPAN) + 32'h4000));
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        for (int i = 0; i < PAGES; i++) m_tab[i] = '0;
        m_en = 0; m_sel = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 lk_vld", {31'b0, lk_vld}, 0);
        chk("R1 lk_fault", {31'b0, lk_fault}, 0);
        chk("R1 lk_paddr", lk_paddr, 0);
        rd(4'h0, v); chk("R1 cfg", v, 0);
        rd_entry("R1 entry", BASE + 32'h5000);

        // R2: config bit 0 only
        wr(4'h0, 32'hFFFF_FFFF); rd(4'h0, v); chk("R2 cfg set", v, 1);
        wr(4'h0, 32'h0000_0002); rd(4'h0, v); chk("R2 cfg clear", v, 0);
        wr(4'h0, 32'h1);

        // R3: select readback
        wr(4'h4, 32'h1234_5678); rd(4'h4, v); chk("R3 sel", v, 32'h1234_5678);

        // R4: program first and last page, low bits dropped
        wr(4'h4, BASE);             wr(4'h8, 32'h8000_1FFF);
        wr(4'h4, BASE + 32'h3F123); wr(4'h8, 32'hFFFF_F000);
        rd_entry("R4 first", BASE);
        rd_entry("R4 last", BASE + 32'h3F000);

        // R6/R7: window edges
        look("R6 below", BASE - 1);
        look("R7 base", BASE + 32'h0ABC);
        look("R7 last byte", BASE + 32'(SPAN) - 1);
        look("R6 past end", BASE + 32'(SPAN));

        // R5: select past end aliases page 0 in low bits; write must be ignored
        wr(4'h4, BASE + 32'(SPAN)); wr(4'h8, 32'h8555_5000);
        rd(4'h8, v); chk("R5 oow read", v, 0);
        rd_entry("R5 page0 untouched", BASE);

        // R4/R8: invalidate then fault
        wr(4'h4, BASE); wr(4'h8, 32'h0);
        look("R8 invalid", BASE + 32'h10);
        wr(4'h4, BASE); wr(4'h8, 32'h8000_7000);
        wr(4'h0, 32'h0);
        look("R8 disabled", BASE + 32'h10);
        wr(4'h0, 32'h1);

        // R9: same-cycle write and lookup of the same entry
        begin
            logic [32:0] e_old;
            e_old = exp_lookup(BASE + 32'h44);
            @(negedge clk);
            reg_wr_en = 1'b1; reg_addr = 4'h8; reg_wdata = 32'h8001_2000;
            lk_req = 1'b1; lk_addr = BASE + 32'h44;
            @(negedge clk);
            reg_wr_en = 1'b0; lk_req = 1'b0;
            m_tab[0] = 32'h8001_2000;
            chk("R9 old value", lk_paddr, e_old[31:0]);
            look("R9 new value", BASE + 32'h44);
        end

        // R10: unused offset, read hold
        wr(4'h0, 32'h1);
        wr(4'hC, 32'h0); rd(4'h0, v); chk("R10 unused write", v, 1);
        rd(4'hC, v); chk("R10 unused read", v, 0);
        rd(4'h0, v);
        repeat (3) @(negedge clk);
        chk("R10 hold", reg_rdata, 1);

        // Random phase (R4, R6, R7, R8)
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom % 8);
            if (op < 3) begin
                wr(4'h4, rnd_addr());
                wr(4'h8, $urandom);
            end else if (op < 4) begin
                rd_entry("R4 rand read", rnd_addr());
            end else if (op < 7) begin
                look("R7 rand lookup", rnd_addr());
            end else begin
                wr(4'h0, ($urandom % 4 == 0) ? 32'h0 : 32'h1);
            end
        end

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule